// File: doc/BRIEF.md
# Dual-Mode Integer ALU Unit

A 32-bit execution stage for eight integer operations chosen by a 3-bit operation code. The first operand always comes from a register read port. The second operand is taken either from a register or from the immediate word that trails the instruction, chosen by one extension bit. A second extension bit switches the arithmetic operations between unsigned and signed behaviour. Logic and shift operations do not depend on that bit.

Add, subtract, AND, OR and the two shifts return one word, which is written to the destination register named by the instruction. Multiply and divide return two words, which go to a dedicated register pair instead of the register file. Every completed operation updates four condition flags. Each operation takes one cycle: an instruction presented with `valid_i` in one cycle shows its results on the outputs after the next rising clock edge. The unit also tells the fetch logic when the trailing immediate word has been consumed and must be skipped.

Top module: `int_alu_unit`

## Requirements
- R1: Operation codes select add (0), subtract (1), multiply (2), divide (3), AND (4), OR (5), shift left (6) and shift right (7). Results appear on the outputs one clock edge after `valid_i`.
- R2: Extension bit 0 selects the second operand: 0 takes `op_b_i`, 1 takes `imm_i`. For codes 0 to 5 with bit 0 set, `pc_skip_o` is 1 in the result cycle; otherwise it is 0.
- R3: The shifts move `op_a_i` by exactly one bit and fill the vacated bit with zero. They ignore both second-operand sources and never raise `pc_skip_o`.
- R4: Extension bit 1 selects the mode: 0 is unsigned and 1 is signed. AND, OR and the shifts return the same result word in both modes.
- R5: Multiply puts the low 32 bits of the 64-bit product on `res_o` and the high 32 bits on `res_hi_o`. It raises `pair_wr_o` and keeps `wr_en_o` low.
- R6: Divide puts the quotient on `res_o` and the remainder on `res_hi_o`, with `pair_wr_o` raised. Signed division truncates toward zero, and the remainder takes the sign of the dividend. Signed 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R7: Every operation other than multiply and divide raises `wr_en_o`, with `wr_addr_o` equal to the `dest_i` field and the result on `res_o`. `wr_en_o` and `pair_wr_o` are never both high.
- R8: `flags_o` is {parity, sign, zero, overflow}, bits 3 down to 0. Zero is set when `res_o` is 0. Sign is bit 31 of `res_o`. Parity is set when `res_o` holds an even number of one bits.
- R9: Overflow in signed mode:
  - add and subtract: signed overflow;
  - multiply: the high word is not the sign extension of the low word;
  - divide: 0x80000000 divided by -1;
  - shift left: bit 31 changes.

  Overflow in unsigned mode:
  - add: carry out;
  - subtract: borrow;
  - multiply: a non-zero high word;
  - each shift: the bit shifted out.

  AND, OR, unsigned divide and signed shift right clear overflow.
- R10: A divide with a zero second operand raises `div_err_o` for one cycle, writes neither destination and leaves `flags_o` unchanged.
- R11: A cycle without `valid_i` writes nothing and leaves `flags_o` unchanged.
- R12: While reset is asserted, and after it is released, every output is 0 until the first valid operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| opcode_i | input | 3 | Operation code |
| ext_i | input | 2 | Bit 0: immediate operand, bit 1: signed mode |
| dest_i | input | 5 | Destination register field |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand from register |
| imm_i | input | 32 | Trailing immediate word |
| wr_en_o | output | 1 | Register file write |
| wr_addr_o | output | 5 | Register file write address |
| res_o | output | 32 | Primary result, or low word for the pair |
| res_hi_o | output | 32 | Secondary result (high product or remainder) |
| pair_wr_o | output | 1 | Special register pair write |
| flags_o | output | 4 | {parity, sign, zero, overflow} |
| pc_skip_o | output | 1 | Immediate word consumed |
| div_err_o | output | 1 | Division by zero |

## Verification
The assertions assume that `valid_i`, `opcode_i`, `ext_i` and the operands are settled and known at each rising edge. They also assume that `rst_ni` is released only while `valid_i` is low, so that the first checked cycle starts from the reset state. The bench changes every input only on the falling edge and holds `valid_i` low through reset and on idle cycles. Values that are don't-care, such as the unused operand source, are driven with definite non-zero patterns. That way an operand selected by mistake changes the result, and the assertions never see unknown values.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned XLEN = 32;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_DIV = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_SHL = 3'd6,
    OP_SHR = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic par;
    logic sgn;
    logic zro;
    logic ovf;
  } alu_flags_t;
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int unsigned W = 32
) (
  input  alu_pkg::alu_op_e op_i,
  input  logic             use_imm_i,
  input  logic [W-1:0]     reg_b_i,
  input  logic [W-1:0]     imm_i,
  output logic [W-1:0]     b_o,
  output logic             skip_o
);
  logic needs_b;

  // shifts take no second operand, so no trailing word is consumed
  assign needs_b = (op_i != alu_pkg::OP_SHL) && (op_i != alu_pkg::OP_SHR);
  assign skip_o  = needs_b && use_imm_i;
  assign b_o     = !needs_b ? '0 : (use_imm_i ? imm_i : reg_b_i);
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int unsigned W = 32
) (
  input  alu_pkg::alu_op_e op_i,
  input  logic             sgn_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic [W-1:0]     res_o,
  output logic [W-1:0]     res_hi_o,
  output logic             ovf_o,
  output logic             dbz_o
);
  localparam int unsigned W2 = 2 * W;
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W:0]    sum_w;
  logic [W-1:0]  diff;
  logic [W2-1:0] a_ext, b_ext, prod;
  logic [W-1:0]  mag_a, mag_b, dvd, dvs, uq, ur, quo, rem;

  assign sum_w = {1'b0, a_i} + {1'b0, b_i};
  assign diff  = a_i - b_i;

  // one multiplier: operands extended per mode, low 2W bits are exact in both
  assign a_ext = sgn_i ? {{W{a_i[W-1]}}, a_i} : {{W{1'b0}}, a_i};
  assign b_ext = sgn_i ? {{W{b_i[W-1]}}, b_i} : {{W{1'b0}}, b_i};
  assign prod  = a_ext * b_ext;

  // one unsigned divider on magnitudes, signs restored afterwards
  assign mag_a = (sgn_i && a_i[W-1]) ? (~a_i + 1'b1) : a_i;
  assign mag_b = (sgn_i && b_i[W-1]) ? (~b_i + 1'b1) : b_i;
  assign dbz_o = (op_i == alu_pkg::OP_DIV) && (b_i == '0);
  assign dvd   = mag_a;
  assign dvs   = (mag_b == '0) ? {{(W-1){1'b0}}, 1'b1} : mag_b;
  assign uq    = dvd / dvs;
  assign ur    = dvd % dvs;
  assign quo   = (sgn_i && (a_i[W-1] ^ b_i[W-1])) ? (~uq + 1'b1) : uq;
  assign rem   = (sgn_i && a_i[W-1]) ? (~ur + 1'b1) : ur;

  always_comb begin
    res_o    = '0;
    res_hi_o = '0;
    ovf_o    = 1'b0;
    unique case (op_i)
      alu_pkg::OP_ADD: begin
        res_o = sum_w[W-1:0];
        ovf_o = sgn_i ? ((a_i[W-1] == b_i[W-1]) && (sum_w[W-1] != a_i[W-1]))
                      : sum_w[W];
      end
      alu_pkg::OP_SUB: begin
        res_o = diff;
        ovf_o = sgn_i ? ((a_i[W-1] != b_i[W-1]) && (diff[W-1] != a_i[W-1]))
                      : (a_i < b_i);
      end
      alu_pkg::OP_MUL: begin
        res_o    = prod[W-1:0];
        res_hi_o = prod[W2-1:W];
        ovf_o    = sgn_i ? (prod[W2-1:W] != {W{prod[W-1]}})
                         : (prod[W2-1:W] != '0);
      end
      alu_pkg::OP_DIV: begin
        res_o    = quo;
        res_hi_o = rem;
        ovf_o    = sgn_i && (a_i == MIN_NEG) && (b_i == '1);
      end
      alu_pkg::OP_AND: res_o = a_i & b_i;
      alu_pkg::OP_OR:  res_o = a_i | b_i;
      alu_pkg::OP_SHL: begin
        res_o = {a_i[W-2:0], 1'b0};
        ovf_o = sgn_i ? (a_i[W-1] ^ a_i[W-2]) : a_i[W-1];
      end
      alu_pkg::OP_SHR: begin
        res_o = {1'b0, a_i[W-1:1]};
        ovf_o = sgn_i ? 1'b0 : a_i[0];
      end
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]        res_i,
  input  logic                ovf_i,
  output alu_pkg::alu_flags_t flags_o
);
  assign flags_o.par = ~^res_i;
  assign flags_o.sgn = res_i[W-1];
  assign flags_o.zro = (res_i == '0);
  assign flags_o.ovf = ovf_i;
endmodule

// File: rtl/int_alu_unit.sv
module int_alu_unit #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        opcode_i,
  input  logic [1:0]        ext_i,
  input  logic [REG_AW-1:0] dest_i,
  input  logic [XLEN-1:0]   op_a_i,
  input  logic [XLEN-1:0]   op_b_i,
  input  logic [XLEN-1:0]   imm_i,
  output logic              wr_en_o,
  output logic [REG_AW-1:0] wr_addr_o,
  output logic [XLEN-1:0]   res_o,
  output logic [XLEN-1:0]   res_hi_o,
  output logic              pair_wr_o,
  output logic [3:0]        flags_o,
  output logic              pc_skip_o,
  output logic              div_err_o
);
  localparam int unsigned IMM_BIT = 0;
  localparam int unsigned SGN_BIT = 1;

  alu_pkg::alu_op_e    op;
  alu_pkg::alu_flags_t flg_n;
  logic [XLEN-1:0]     b_sel, r_lo, r_hi;
  logic                skip, ovf, dbz, is_pair;

  assign op      = alu_pkg::alu_op_e'(opcode_i);
  assign is_pair = (op == alu_pkg::OP_MUL) || (op == alu_pkg::OP_DIV);

  alu_operand_sel #(.W(XLEN)) i_sel (
    .op_i      (op),
    .use_imm_i (ext_i[IMM_BIT]),
    .reg_b_i   (op_b_i),
    .imm_i     (imm_i),
    .b_o       (b_sel),
    .skip_o    (skip)
  );

  alu_core #(.W(XLEN)) i_core (
    .op_i     (op),
    .sgn_i    (ext_i[SGN_BIT]),
    .a_i      (op_a_i),
    .b_i      (b_sel),
    .res_o    (r_lo),
    .res_hi_o (r_hi),
    .ovf_o    (ovf),
    .dbz_o    (dbz)
  );

  alu_flag_gen #(.W(XLEN)) i_flags (
    .res_i   (r_lo),
    .ovf_i   (ovf),
    .flags_o (flg_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      res_o     <= '0;
      res_hi_o  <= '0;
      pair_wr_o <= 1'b0;
      flags_o   <= '0;
      pc_skip_o <= 1'b0;
      div_err_o <= 1'b0;
    end else begin
      wr_en_o   <= valid_i && !is_pair;
      pair_wr_o <= valid_i && is_pair && !dbz;
      pc_skip_o <= valid_i && skip;
      div_err_o <= valid_i && dbz;
      if (valid_i) begin
        wr_addr_o <= dest_i;
        res_o     <= r_lo;
        res_hi_o  <= r_hi;
        if (!dbz) flags_o <= flg_n;
      end
    end
  end

  // R10
  div_err_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o |-> (!wr_en_o && !pair_wr_o));

  // R10
  div_err_flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == alu_pkg::OP_DIV && b_sel == '0) |=> $stable(flags_o));

  // R7
  single_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && pair_wr_o));

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!wr_en_o && !pair_wr_o && $stable(flags_o)));

  // R8
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && flags_o[1]) |-> (res_o == '0));

  // R3
  shift_no_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i[2:1] == 2'b11) |=> !pc_skip_o);

  // R3
  shr_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == alu_pkg::OP_SHR) |=> (res_o[XLEN-1] == 1'b0));
endmodule

// File: tb/test_int_alu_unit.sv
module test_int_alu_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  ext;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] imm;
    logic [31:0] res;
    logic [31:0] hi;
    logic [3:0]  flg;
    logic        skip;
  } vec_t;

  // flags = {parity, sign, zero, overflow}
  localparam vec_t TBL [NV] = '{
    '{3'd0, 2'd0, 32'h5,        32'h7,        32'h99,     32'hC,        32'h0,        4'h8, 1'b0},
    '{3'd0, 2'd0, 32'hFFFFFFFF, 32'h1,        32'h99,     32'h0,        32'h0,        4'hB, 1'b0},
    '{3'd0, 2'd2, 32'h7FFFFFFF, 32'h1,        32'h99,     32'h80000000, 32'h0,        4'h5, 1'b0},
    '{3'd1, 2'd0, 32'h3,        32'h5,        32'h99,     32'hFFFFFFFE, 32'h0,        4'h5, 1'b0},
    '{3'd1, 2'd2, 32'h3,        32'h5,        32'h99,     32'hFFFFFFFE, 32'h0,        4'h4, 1'b0},
    '{3'd2, 2'd1, 32'h10000,    32'h5,        32'h10000,  32'h0,        32'h1,        4'hB, 1'b1},
    '{3'd2, 2'd2, 32'hFFFFFFFE, 32'h3,        32'h99,     32'hFFFFFFFA, 32'hFFFFFFFF, 4'hC, 1'b0},
    '{3'd3, 2'd0, 32'h64,       32'h7,        32'h99,     32'hE,        32'h2,        4'h0, 1'b0},
    '{3'd3, 2'd2, 32'hFFFFFFF9, 32'h2,        32'h99,     32'hFFFFFFFD, 32'hFFFFFFFF, 4'h4, 1'b0},
    '{3'd3, 2'd2, 32'h80000000, 32'hFFFFFFFF, 32'h99,     32'h80000000, 32'h0,        4'h5, 1'b0},
    '{3'd4, 2'd0, 32'hF0F0F0F0, 32'hFF00FF00, 32'h99,     32'hF000F000, 32'h0,        4'hC, 1'b0},
    '{3'd5, 2'd3, 32'h0,        32'h1234,     32'h0,      32'h0,        32'h0,        4'hA, 1'b1},
    '{3'd6, 2'd1, 32'h80000001, 32'hFFFFFFFF, 32'h55,     32'h2,        32'h0,        4'h1, 1'b0},
    '{3'd6, 2'd2, 32'h40000000, 32'hFFFFFFFF, 32'h55,     32'h80000000, 32'h0,        4'h5, 1'b0},
    '{3'd7, 2'd0, 32'h80000003, 32'hFFFFFFFF, 32'h55,     32'h40000001, 32'h0,        4'h9, 1'b0},
    '{3'd7, 2'd2, 32'h80000000, 32'hFFFFFFFF, 32'h55,     32'h40000000, 32'h0,        4'h0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  opcode = '0;
  logic [1:0]  ext = '0;
  logic [4:0]  dest = '0;
  logic [31:0] op_a = '0, op_b = '0, imm = '0;
  logic        wr_en, pair_wr, pc_skip, div_err;
  logic [4:0]  wr_addr;
  logic [31:0] res, res_hi;
  logic [3:0]  flags;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu_unit i_int_alu_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .opcode_i(opcode),
    .ext_i(ext), .dest_i(dest), .op_a_i(op_a), .op_b_i(op_b), .imm_i(imm),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .res_o(res), .res_hi_o(res_hi),
    .pair_wr_o(pair_wr), .flags_o(flags), .pc_skip_o(pc_skip),
    .div_err_o(div_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive on the falling edge, sample on the next falling edge (one register)
  task automatic issue(input logic [2:0] o, input logic [1:0] e, input logic [4:0] d,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] im);
    valid = 1'b1; opcode = o; ext = e; dest = d; op_a = a; op_b = b; imm = im;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic idle();
    valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] held;
    string tag;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset outputs", {wr_en, pair_wr, pc_skip, div_err, flags, wr_addr, res}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 after release", {wr_en, pair_wr, flags, res_hi}, '0);

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].op, TBL[i].ext, 5'(i + 1), TBL[i].a, TBL[i].b, TBL[i].imm);
      case (TBL[i].op)
        3'd2: tag = "R5";
        3'd3: tag = "R6";
        3'd6, 3'd7: tag = "R3";
        default: tag = "R1";
      endcase
      if (TBL[i].op == 3'd2 || TBL[i].op == 3'd3) begin
        chk({tag, " pair write"}, {wr_en, pair_wr}, 2'b01);
        chk({tag, " hi word"}, res_hi, TBL[i].hi);
      end else begin
        chk("R7 reg write", {wr_en, pair_wr, wr_addr}, {2'b10, 5'(i + 1)});
      end
      chk({tag, " result"}, res, TBL[i].res);
      chk("R8 R9 flags", flags, TBL[i].flg);
      chk("R2 skip", pc_skip, TBL[i].skip);
    end

    // R4: logic result independent of mode
    issue(3'd4, 2'd2, 5'd9, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0);
    chk("R4 signed AND", res, 32'hF000F000);
    issue(3'd7, 2'd0, 5'd9, 32'h80000000, 32'h0, 32'h0);
    chk("R4 unsigned SHR", res, 32'h40000000);

    // R2: immediate path ignores register operand
    issue(3'd0, 2'd1, 5'd3, 32'h10, 32'hFFFF0000, 32'h5);
    chk("R2 imm add", {res, pc_skip}, {32'h15, 1'b1});
    issue(3'd0, 2'd0, 5'd3, 32'h10, 32'h5, 32'hFFFF0000);
    chk("R2 reg add", {res, pc_skip}, {32'h15, 1'b0});
    // R3: shift with different second operands gives same result
    issue(3'd6, 2'd0, 5'd4, 32'h3, 32'h12345678, 32'h0);
    chk("R3 shl ignores b", res, 32'h6);
    held = flags;

    // R11 idle
    idle();
    chk("R11 idle no write", {wr_en, pair_wr}, 2'b00);
    chk("R11 idle flags", flags, held);

    // R10 divide by zero (register and immediate)
    issue(3'd3, 2'd0, 5'd6, 32'h64, 32'h0, 32'h7);
    chk("R10 err", {div_err, wr_en, pair_wr}, 3'b100);
    chk("R10 flags held", flags, held);
    issue(3'd3, 2'd3, 5'd6, 32'h64, 32'h7, 32'h0);
    chk("R10 err imm", {div_err, wr_en, pair_wr, pc_skip}, 4'b1001);
    chk("R10 flags held imm", flags, held);
    idle();
    chk("R10 err one cycle", div_err, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule